// File: doc/BRIEF.md
# Sine and Cosine Interpolating Accelerator

This block is a register-mapped slave that turns an unsigned 32-bit phase word into its sine and its cosine. The whole 2^32 range of the phase word spans one full turn, so one LSB is 2π/2^32 rad. The top 11 bits select an entry in two constant tables, which hold the sine and the cosine of the 2048 coarse angles. The remaining 21 bits form a small residual angle b. The block adds a first-order correction term: sine becomes S + b·C and cosine becomes C − b·S. To scale the residual to radians it multiplies by a fixed 2π constant and shifts, so there is no divider anywhere.

Software writes the phase to one register. The datapath in front of the result registers evaluates both functions in the same cycle. The very next access can read either result. The bus side is a single-beat valid/ready request channel. Ready is always high, so there is no back-pressure: every request completes in the cycle where valid is high. A read returns its data combinationally in that same cycle. Both tables are computed during elaboration by a constant integer function, so no memory image is needed.

Top module: `sincos_accel`

## Requirements
- R1: A write to byte address 0x0 loads the phase register. A read from 0x0 in any later cycle returns the written value.
- R2: Sine is read at address 0x4 and cosine at address 0x8. Both are 32-bit two's-complement values with 30 fractional bits, so 1.0 reads as 0x40000000.
- R3: Both results for a newly written phase can be read in the cycle right after the write.
- R4: When the low 21 phase bits are zero, sine and cosine equal sin and cos of idx·2π/2048 within 3e-9, where idx is the top 11 bits.
- R5: For any phase, each result is within 5e-6 of the exact sine or cosine of phase·2π/2^32.
- R6: Writes to 0x4 or 0x8 are ignored. The phase, sine and cosine all keep their values.
- R7: A read from any address other than 0x0, 0x4 or 0x8 returns zero. A write to such an address changes nothing.
- R8: After reset, the phase reads 0, the sine reads 0 and the cosine reads 0x40000000.
- R9: bus_ready is always 1. Without an accepted write to 0x0, the sine and cosine keep their values over any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Request present this cycle |
| bus_ready | output | 1 | Request accepted; constant 1 |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read request |

## Verification
The hardest case to reach from the ports is the worst interpolation error. It occurs only where the residual sits just below the next table step, and only when the product with the crossed table is largest. Random phases seldom land there. The stimulus therefore sweeps every one of the 2048 table indices twice: once with a zero residual, which isolates table accuracy, and once with an all-ones residual, which maximises the correction term. Random phases from a shift generator then cover the interior.

// File: rtl/sincos_pkg.sv
package sincos_pkg;
  localparam int ANGLE_W = 32;
  localparam int DATA_W  = 32;
  localparam int FRAC_W  = 30;
  localparam int ADDR_W  = 4;
  // residual radians are carried with this many fractional bits
  localparam int B_FRAC  = 40;
  localparam int K_FRAC  = 29;

  localparam logic [ADDR_W-1:0] A_PHASE = 4'h0;
  localparam logic [ADDR_W-1:0] A_SINE  = 4'h4;
  localparam logic [ADDR_W-1:0] A_COSN  = 4'h8;

  // round(2*pi * 2^29)
  localparam logic [31:0] TWO_PI_K = 32'd3373259426;
  // continued-fraction convergent of pi
  localparam longint PI_NUM = 64'd245850922;
  localparam longint PI_DEN = 64'd78256779;

  localparam logic signed [DATA_W-1:0] ONE_Q = DATA_W'(1) <<< FRAC_W;

  // sine of idx*2pi/depth in Q30, from a Q60 Taylor series on one quadrant
  function automatic logic signed [DATA_W-1:0] sin_entry(input int unsigned idx,
                                                         input int unsigned depth);
    logic signed [127:0] x, x2, term, acc, rnd;
    int unsigned quart, qd, r;
    quart = depth / 4;
    qd = (idx % depth) / quart;
    r  = (idx % depth) % quart;
    if (qd[0]) r = quart - r;
    x = ((128'(r) << 60) * 128'(PI_NUM)) / (128'(PI_DEN) * 128'(2 * quart));
    x2 = (x * x) >>> 60;
    term = x;
    acc = x;
    for (int k = 1; k <= 9; k++) begin
      term = (term * x2) >>> 60;
      term = term / $signed(128'(2 * k * (2 * k + 1)));
      term = -term;
      acc = acc + term;
    end
    rnd = (acc + (128'(1) <<< 29)) >>> 30;
    if (qd >= 2) rnd = -rnd;
    return DATA_W'(rnd);
  endfunction
endpackage

// File: rtl/sincos_rom.sv
module sincos_rom #(
  parameter int IDX_W = 11,
  parameter int PHASE = 0
) (
  input  logic [IDX_W-1:0]                   idx,
  output logic signed [sincos_pkg::DATA_W-1:0] val
);
  localparam int DEPTH = 1 << IDX_W;

  logic signed [sincos_pkg::DATA_W-1:0] tab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign tab[i] = sincos_pkg::sin_entry(i + PHASE, DEPTH);
  end

  assign val = tab[idx];
endmodule

// File: rtl/sincos_interp.sv
module sincos_interp #(
  parameter int IDX_W = 11
) (
  input  logic [sincos_pkg::ANGLE_W-1:0]       angle,
  output logic [IDX_W-1:0]                     idx,
  input  logic signed [sincos_pkg::DATA_W-1:0] sin_t,
  input  logic signed [sincos_pkg::DATA_W-1:0] cos_t,
  output logic signed [sincos_pkg::DATA_W-1:0] sin_y,
  output logic signed [sincos_pkg::DATA_W-1:0] cos_y
);
  import sincos_pkg::*;
  localparam int RES_W = ANGLE_W - IDX_W;
  localparam int RK_W  = RES_W + 32;
  localparam int SHIFT = K_FRAC + ANGLE_W - B_FRAC;
  localparam int P_W   = 33 + DATA_W;

  logic [RES_W-1:0]       res;
  logic [RK_W-1:0]        rk;
  logic [31:0]            b_q;
  logic signed [P_W-1:0]  b_ext, s_ext, c_ext, p_s, p_c;

  assign idx = angle[ANGLE_W-1 -: IDX_W];
  assign res = angle[RES_W-1:0];

  // residual in radians, unsigned with B_FRAC fractional bits
  assign rk  = RK_W'(res) * RK_W'(TWO_PI_K);
  assign b_q = 32'(rk >> SHIFT);

  assign b_ext = $signed({{(P_W-32){1'b0}}, b_q});
  assign s_ext = P_W'(sin_t);
  assign c_ext = P_W'(cos_t);
  assign p_s   = b_ext * c_ext;
  assign p_c   = b_ext * s_ext;

  assign sin_y = sin_t + DATA_W'(p_s >>> B_FRAC);
  assign cos_y = cos_t - DATA_W'(p_c >>> B_FRAC);
endmodule

// File: rtl/sincos_accel.sv
module sincos_accel #(
  parameter int IDX_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  output logic        bus_ready,
  input  logic        bus_write,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  import sincos_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic [ANGLE_W-1:0]       angle_q;
  logic signed [DATA_W-1:0] sin_q, cos_q;
  logic [IDX_W-1:0]         idx;
  logic signed [DATA_W-1:0] sin_t, cos_t, sin_y, cos_y;
  logic                     ld_phase;

  sincos_rom #(.IDX_W(IDX_W), .PHASE(0)) u_sin_rom (
    .idx(idx), .val(sin_t)
  );
  sincos_rom #(.IDX_W(IDX_W), .PHASE(DEPTH / 4)) u_cos_rom (
    .idx(idx), .val(cos_t)
  );
  sincos_interp #(.IDX_W(IDX_W)) u_interp (
    .angle(bus_wdata), .idx(idx), .sin_t(sin_t), .cos_t(cos_t),
    .sin_y(sin_y), .cos_y(cos_y)
  );

  assign bus_ready = 1'b1;
  assign ld_phase  = bus_valid && bus_write && (bus_addr == A_PHASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle_q <= '0;
      sin_q   <= '0;
      cos_q   <= ONE_Q;
    end else if (ld_phase) begin
      angle_q <= bus_wdata;
      sin_q   <= sin_y;
      cos_q   <= cos_y;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_PHASE: bus_rdata = angle_q;
        A_SINE:  bus_rdata = sin_q;
        A_COSN:  bus_rdata = cos_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sincos_accel_chk.sv
module sincos_accel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] angle_q,
  input logic [31:0] sin_q,
  input logic [31:0] cos_q
);
  logic wr_phase, wr_other, rd_unmapped;
  assign wr_phase = bus_valid && bus_write && (bus_addr == 4'h0);
  assign wr_other = bus_valid && bus_write && (bus_addr != 4'h0);
  assign rd_unmapped = bus_valid && !bus_write && (bus_addr != 4'h0)
                       && (bus_addr != 4'h4) && (bus_addr != 4'h8);

  assert_phase_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |=> angle_q == $past(bus_wdata));

  assert_ro_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> $stable(angle_q) && $stable(sin_q) && $stable(cos_q));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_phase |=> $stable(sin_q) && $stable(cos_q));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> bus_rdata == 32'h0);

  assert_result_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(sin_q) <= 32'sd1077936128) && ($signed(sin_q) >= -32'sd1077936128) &&
    ($signed(cos_q) <= 32'sd1077936128) && ($signed(cos_q) >= -32'sd1077936128));
endmodule

bind sincos_accel sincos_accel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .angle_q(angle_q), .sin_q(sin_q), .cos_q(cos_q)
);

// File: tb/sincos_accel_tb.sv
module sincos_accel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  localparam real TWO_PI = 6.283185307179586;
  localparam real QSCALE = 1073741824.0;

  always #2 clk = ~clk;

  sincos_accel dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk_int(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_real(input string req, input logic [31:0] got, input real exp, input real tol);
    real g, e;
    g = real'($signed(got)) / QSCALE;
    e = g - exp;
    if (e < 0.0) e = -e;
    checks++;
    if (e > tol) begin
      failures++;
      $display("FAIL %s got=%.10f exp=%.10f", req, g, exp);
    end
  endtask

  // R3, R4, R5: write a phase, read both results the next cycle
  task automatic phase_check(input logic [31:0] ph, input string req, input real tol);
    logic [31:0] s, c;
    real ang;
    ang = real'(ph) * TWO_PI / 4294967296.0;
    do_write(4'h0, ph);
    do_read(4'h4, s);
    chk_real(req, s, $sin(ang), tol);
    do_read(4'h8, c);
    chk_real(req, c, $cos(ang), tol);
  endtask

  initial begin
    logic [31:0] v, s0, c0, lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset values
    do_read(4'h0, v); chk_int("R8 phase", v, 32'h0);
    do_read(4'h4, v); chk_int("R8 sine", v, 32'h0);
    do_read(4'h8, v); chk_int("R8 cosine", v, 32'h40000000);
    // R9 ready high
    checks++;
    if (bus_ready !== 1'b1) begin failures++; $display("FAIL R9 ready got=%b exp=1", bus_ready); end
    // R4 table points: every index, zero residual
    for (int i = 0; i < 2048; i++) phase_check(32'(i) << 21, "R4", 3.0e-9);
    // R5 worst residual on every index
    for (int i = 0; i < 2048; i++) phase_check((32'(i) << 21) | 32'h001F_FFFF, "R5", 5.0e-6);
    // R5 random phases, R1 readback
    lf = 32'h1234_5678;
    for (int i = 0; i < 1000; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      phase_check(lf, "R5", 5.0e-6);
      if (i % 50 == 0) begin
        do_read(4'h0, v); chk_int("R1 readback", v, lf);
      end
    end
    // R6 writes to result addresses ignored
    phase_check(32'h2AAA_AAAB, "R3", 5.0e-6);
    do_read(4'h4, s0); do_read(4'h8, c0);
    do_write(4'h4, 32'hDEAD_BEEF);
    do_write(4'h8, 32'h0BAD_F00D);
    do_read(4'h0, v); chk_int("R6 phase", v, 32'h2AAA_AAAB);
    do_read(4'h4, v); chk_int("R6 sine", v, s0);
    do_read(4'h8, v); chk_int("R6 cosine", v, c0);
    // R7 unmapped
    do_write(4'hC, 32'h5555_5555);
    do_read(4'hC, v); chk_int("R7 read zero", v, 32'h0);
    do_read(4'h0, v); chk_int("R7 phase", v, 32'h2AAA_AAAB);
    // R9 results hold over idle cycles
    repeat (20) @(negedge clk);
    do_read(4'h4, v); chk_int("R9 sine hold", v, s0);
    do_read(4'h8, v); chk_int("R9 cosine hold", v, c0);
    // R2 encoding: quarter turn gives sine 1.0 and cosine 0
    do_write(4'h0, 32'h4000_0000);
    do_read(4'h4, v); chk_int("R2 sine one", v, 32'h40000000);
    do_read(4'h8, v); chk_int("R2 cosine zero", v, 32'h0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule